// File: doc/BRIEF.md
# Guarded Two-Stage Clock Source Selector

This block picks the system clock of a small microcontroller from three oscillators: a fast internal one, a fast external one and a slow one. It works in two stages. Stage one picks the high-speed clock from the two fast oscillators. Stage two picks the system clock from that high-speed clock or from the slow oscillator. Each stage is a glitch-free handoff multiplexer. The old source's enable is taken down on that source's falling edge. Only after that is seen does the new source's enable pass through a synchronizer in its own domain and rise on its falling edge.

Software controls the block through two registers on a simple bus clocked by `bus_clk`. Address 0 holds the two source-select bits. Address 1 holds the three oscillator enables. Each oscillator also returns a stable flag. An oscillator counts as running only when its enable is set and its stable flag has been seen. Interlock logic refuses any select change that would pick an oscillator that is not running, or that would start a new handoff while one is still in progress. It also refuses to switch off an oscillator that drives the system clock or is still being handed off. A refused write leaves the stored bit unchanged. Reads always return the values that were accepted.

Top module: `clk_source_guard`

## Requirements
- R1: While reset is held and after it is released, address 0 reads 0x00, address 1 reads 0x01, `osc_en` is 3'b001, and both `hs_src` and `sys_src` read 2'b01. Address 0 bit 1 = 0 means the fast internal oscillator; address 0 bit 0 = 0 means the high-speed clock. Address 1 bit 0 = fast internal, bit 1 = fast external, bit 2 = slow.
- R2: A write to address 0 updates bit 1 (1 = fast external, 0 = fast internal) only if three things hold: both fast oscillators have their enable set, both fast oscillators have their stable flag synchronized into `bus_clk`, and stage one is not mid-handoff. Otherwise bit 1 keeps its value.
- R3: A write to address 0 updates bit 0 (1 = slow, 0 = high-speed) only if three things hold: the slow oscillator is running, the fast oscillator chosen by the current bit 1 is running, and stage two is not mid-handoff. Otherwise bit 0 keeps its value.
- R4: A write to address 1 loads the three enable bits from data bits 2:0, with these exceptions, which stay at 1:
  - the slow enable, if address 0 bit 0 is set or stage two still reports the slow source;
  - a fast enable, if the system uses the high-speed clock (bit 0 clear, or stage two still reports high-speed) and that fast oscillator is either selected by bit 1 or still reported by stage one.
- R5: While a stage's status does not equal the one-hot code of its accepted select bit, a write that would change that bit is refused.
- R6: Reads return the accepted register values with all unused upper bits zero, and `osc_en` always equals the enable register.
- R7: `hs_src` (bit 0 = internal, bit 1 = external) and `sys_src` (bit 0 = high-speed, bit 1 = slow) never have two bits set. Once a handoff has settled, each equals the one-hot code of the accepted select bit.
- R8: No high or low phase on `hs_clk` or `sys_clk` is shorter than half a period of the fastest source clock feeding it. A handoff only stretches a low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register and interlock clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_int_clk | input | 1 | Fast internal oscillator clock |
| fast_ext_clk | input | 1 | Fast external oscillator clock |
| slow_clk | input | 1 | Slow oscillator clock |
| osc_stable | input | 3 | Stable flags, bit order as the enable register |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 selects, 1 enables |
| wr_data | input | DW | Write data |
| rd_addr | input | 1 | Read address: 0 selects, 1 enables |
| rd_data | output | DW | Read data, combinational from `rd_addr` |
| osc_en | output | 3 | Oscillator enables |
| hs_clk | output | 1 | High-speed clock from stage one |
| sys_clk | output | 1 | System clock from stage two |
| hs_src | output | 2 | Stage one source actually driving, synchronized to `bus_clk` |
| sys_src | output | 2 | Stage two source actually driving, synchronized to `bus_clk` |

## Verification
The bench enables the external oscillator and, before its stable flag can arrive, tries to select it. A design that checked only the enable bit would switch onto a clock that is not yet valid. It also writes a new select value a few cycles after a previous change, while that stage is still handing off. A design without the handoff guard would accept it and could leave both enables of a stage high, which shows up as a wrong read-back or a narrow pulse on the clock output. It then tries to switch off the slow oscillator while it drives the system clock, and the selected fast oscillator while the high-speed clock is in use. A design that dropped those interlocks would stop `sys_clk` or `hs_clk`. A pulse-width monitor on both clock outputs flags any phase shorter than half the fastest source period. That catches a multiplexer that overlaps enables or updates them on the wrong edge.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
package clksel_pkg;
  localparam int NUM_OSC = 3;
  localparam int OSC_INT = 0;
  localparam int OSC_EXT = 1;
  localparam int OSC_SLOW = 2;
  localparam int SEL_HS_BIT = 1;
  localparam int SEL_SYS_BIT = 0;
  localparam logic ADDR_SEL = 1'b0;
  localparam logic ADDR_EN = 1'b1;
  localparam logic [NUM_OSC-1:0] EN_RESET = NUM_OSC'(1) << OSC_INT;

  typedef struct packed {
    logic hs_ext;
    logic sys_slow;
  } sel_t;

  function automatic logic [1:0] src_code(input logic b);
    return b ? 2'b10 : 2'b01;
  endfunction
endpackage

// File: rtl/cdc_sync.sv
`timescale 1ns/1ps
module cdc_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;
  logic [STAGES-1:0][WIDTH-1:0] pipe_d;

  always_comb begin
    pipe_d[0] = d;
    for (int s = 1; s < STAGES; s++) pipe_d[s] = pipe_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
    else        pipe_q <= pipe_d;
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/gf_clk_mux.sv
`timescale 1ns/1ps
module gf_clk_mux #(
  parameter int RST_SRC = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic       rst_n,
  input  logic [1:0] clk_src,
  input  logic       sel,
  output logic       clk_out,
  output logic [1:0] active
);
  logic [1:0] en_q;
  logic [1:0] gated;

  for (genvar i = 0; i < 2; i++) begin : g_leg
    logic want;
    logic want_s;
    logic en_r;

    assign want = (sel == 1'(i)) && !en_q[1-i];

    cdc_sync #(
      .WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'(RST_SRC == i))
    ) u_sync (
      .clk(clk_src[i]), .rst_n(rst_n), .d(want), .q(want_s)
    );

    always_ff @(negedge clk_src[i] or negedge rst_n) begin
      if (!rst_n) en_r <= 1'(RST_SRC == i);
      else        en_r <= want_s;
    end

    assign en_q[i]  = en_r;
    assign gated[i] = clk_src[i] & en_r;
  end

  assign clk_out = |gated;
  assign active  = en_q;

  // R7: the two legs of a handoff never drive the output together
  always_comb begin
    if (rst_n) p_no_overlap_r7: assert (!(en_q[0] && en_q[1]));
  end
endmodule

// File: rtl/clksel_regs.sv
`timescale 1ns/1ps
module clksel_regs
  import clksel_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic               rd_addr,
  input  logic [NUM_OSC-1:0] stable_s,
  input  logic [1:0]         hs_src_s,
  input  logic [1:0]         sys_src_s,
  output logic [DW-1:0]      rd_data,
  output sel_t               sel_q,
  output logic [NUM_OSC-1:0] osc_en_q
);
  localparam sel_t SEL_RST = '{hs_ext: 1'b0, sys_slow: 1'b0};

  logic [NUM_OSC-1:0] run, keep, en_d;
  logic hs_idle, sys_idle, hs_run, hs_ok, sys_ok, hs_used;
  logic sel_we, en_we;
  sel_t sel_d;
  logic wr_unused;

  assign wr_unused = ^wr_data[DW-1:NUM_OSC];

  always_comb begin
    run      = osc_en_q & stable_s;
    hs_idle  = (hs_src_s == src_code(sel_q.hs_ext));
    sys_idle = (sys_src_s == src_code(sel_q.sys_slow));
    hs_run   = sel_q.hs_ext ? run[OSC_EXT] : run[OSC_INT];
    hs_ok    = run[OSC_INT] & run[OSC_EXT] & hs_idle;
    sys_ok   = run[OSC_SLOW] & hs_run & sys_idle;

    hs_used        = !sel_q.sys_slow | sys_src_s[0];
    keep[OSC_SLOW] = sel_q.sys_slow | sys_src_s[1];
    keep[OSC_INT]  = hs_used & (!sel_q.hs_ext | hs_src_s[0]);
    keep[OSC_EXT]  = hs_used & (sel_q.hs_ext | hs_src_s[1]);

    sel_we = wr_en && (wr_addr == ADDR_SEL);
    en_we  = wr_en && (wr_addr == ADDR_EN);

    sel_d = sel_q;
    if (hs_ok)  sel_d.hs_ext   = wr_data[SEL_HS_BIT];
    if (sys_ok) sel_d.sys_slow = wr_data[SEL_SYS_BIT];
    en_d = wr_data[NUM_OSC-1:0] | keep;

    rd_data = '0;
    if (rd_addr == ADDR_EN) begin
      rd_data[NUM_OSC-1:0] = osc_en_q;
    end else begin
      rd_data[SEL_HS_BIT]  = sel_q.hs_ext;
      rd_data[SEL_SYS_BIT] = sel_q.sys_slow;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= SEL_RST;
      osc_en_q <= EN_RESET;
    end else begin
      if (sel_we) sel_q    <= sel_d;
      if (en_we)  osc_en_q <= en_d;
    end
  end

  p_hs_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q.hs_ext != $past(sel_q.hs_ext)) |-> $past(run[OSC_INT] && run[OSC_EXT]));

  p_sys_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q.sys_slow && !$past(sel_q.sys_slow)) |-> $past(run[OSC_SLOW]));

  p_keep_slow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q.sys_slow || sys_src_s[1]) |-> osc_en_q[OSC_SLOW]);

  p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_src_s != src_code(sel_q.hs_ext)) |=> $stable(sel_q.hs_ext));

  p_src_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hs_src_s) && $onehot0(sys_src_s));
endmodule

// File: rtl/clk_source_guard.sv
`timescale 1ns/1ps
module clk_source_guard
  import clksel_pkg::*;
#(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          bus_clk,
  input  logic          rst_n,
  input  logic          fast_int_clk,
  input  logic          fast_ext_clk,
  input  logic          slow_clk,
  input  logic [2:0]    osc_stable,
  input  logic          wr_en,
  input  logic          wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [2:0]    osc_en,
  output logic          hs_clk,
  output logic          sys_clk,
  output logic [1:0]    hs_src,
  output logic [1:0]    sys_src
);
  logic bus_rst_n;
  logic [NUM_OSC-1:0] stable_s;
  logic [1:0] hs_act, sys_act;
  sel_t sel_q;

  cdc_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(bus_clk), .rst_n(rst_n), .d(1'b1), .q(bus_rst_n)
  );

  cdc_sync #(.WIDTH(NUM_OSC), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_stable_sync (
    .clk(bus_clk), .rst_n(rst_n), .d(osc_stable), .q(stable_s)
  );

  gf_clk_mux #(.RST_SRC(0), .SYNC_STAGES(SYNC_STAGES)) u_hs_mux (
    .rst_n(rst_n), .clk_src({fast_ext_clk, fast_int_clk}), .sel(sel_q.hs_ext),
    .clk_out(hs_clk), .active(hs_act)
  );

  gf_clk_mux #(.RST_SRC(0), .SYNC_STAGES(SYNC_STAGES)) u_sys_mux (
    .rst_n(rst_n), .clk_src({slow_clk, hs_clk}), .sel(sel_q.sys_slow),
    .clk_out(sys_clk), .active(sys_act)
  );

  cdc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_hs_stat_sync (
    .clk(bus_clk), .rst_n(rst_n), .d(hs_act), .q(hs_src)
  );

  cdc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sys_stat_sync (
    .clk(bus_clk), .rst_n(rst_n), .d(sys_act), .q(sys_src)
  );

  clksel_regs #(.DW(DW)) u_regs (
    .clk(bus_clk), .rst_n(bus_rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .stable_s(stable_s),
    .hs_src_s(hs_src), .sys_src_s(sys_src), .rd_data(rd_data),
    .sel_q(sel_q), .osc_en_q(osc_en)
  );
endmodule

// File: tb/sim_clk_source_guard.sv
`timescale 1ns/1ps
module sim_clk_source_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fi_clk = 1'b0, fe_clk = 1'b0, sl_clk = 1'b0;
  logic wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [2:0] osc_en, osc_stable;
  logic hs_clk, sys_clk;
  logic [1:0] hs_src, sys_src;

  int n_cmp = 0, n_bad = 0;
  int hs_narrow = 0, sys_narrow = 0, sys_edges = 0;
  realtime hs_last = -1.0, sys_last = -1.0;
  bit done = 0;

  localparam real MIN_PHASE = 6.99;

  always #5 clk = ~clk;

  assign #50 osc_stable = osc_en;

  initial forever begin
    if (osc_en[0] === 1'b1) begin #7 fi_clk = 1'b1; #7 fi_clk = 1'b0; end else #1;
  end
  initial forever begin
    if (osc_en[1] === 1'b1) begin #9 fe_clk = 1'b1; #9 fe_clk = 1'b0; end else #1;
  end
  initial forever begin
    if (osc_en[2] === 1'b1) begin #37 sl_clk = 1'b1; #37 sl_clk = 1'b0; end else #1;
  end

  clk_source_guard u0 (
    .bus_clk(clk), .rst_n(rst_n), .fast_int_clk(fi_clk), .fast_ext_clk(fe_clk),
    .slow_clk(sl_clk), .osc_stable(osc_stable), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .osc_en(osc_en),
    .hs_clk(hs_clk), .sys_clk(sys_clk), .hs_src(hs_src), .sys_src(sys_src)
  );

  // R8 pulse-width monitor
  always @(rst_n) begin hs_last = -1.0; sys_last = -1.0; end
  always @(hs_clk) begin
    if (rst_n === 1'b1) begin
      if (hs_last >= 0.0 && ($realtime - hs_last) < MIN_PHASE) hs_narrow++;
      hs_last = $realtime;
    end
  end
  always @(sys_clk) begin
    if (rst_n === 1'b1) begin
      if (sys_last >= 0.0 && ($realtime - sys_last) < MIN_PHASE) sys_narrow++;
      sys_last = $realtime;
      sys_edges++;
    end
  end

  typedef struct packed {
    logic       wa;
    logic [7:0] wd;
    logic [7:0] wt;
    logic [1:0] exp_sel;
    logic [2:0] exp_en;
    logic       chk_st;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h02, 8'd100, 2'b00, 3'b001, 1'b1, 4'd2}, // R2 ext not enabled
    '{1'b1, 8'h03, 8'd1,   2'b00, 3'b011, 1'b0, 4'd6}, // R6 enable ext
    '{1'b0, 8'h02, 8'd100, 2'b00, 3'b011, 1'b1, 4'd2}, // R2 ext not yet stable
    '{1'b0, 8'h02, 8'd100, 2'b10, 3'b011, 1'b1, 4'd2}, // R2 accepted
    '{1'b1, 8'h02, 8'd100, 2'b10, 3'b010, 1'b1, 4'd4}, // R4 idle int may stop
    '{1'b0, 8'h00, 8'd100, 2'b10, 3'b010, 1'b1, 4'd2}, // R2 int stopped
    '{1'b0, 8'h03, 8'd100, 2'b10, 3'b010, 1'b1, 4'd3}, // R3 slow stopped
    '{1'b1, 8'h06, 8'd100, 2'b10, 3'b110, 1'b1, 4'd6}, // R6 enable slow
    '{1'b0, 8'h03, 8'd100, 2'b11, 3'b110, 1'b1, 4'd3}, // R3 accepted
    '{1'b1, 8'h04, 8'd100, 2'b11, 3'b100, 1'b1, 4'd4}, // R4 ext unused now
    '{1'b1, 8'h00, 8'd100, 2'b11, 3'b100, 1'b1, 4'd4}, // R4 slow protected
    '{1'b0, 8'h02, 8'd100, 2'b11, 3'b100, 1'b1, 4'd3}, // R3 hs not running
    '{1'b1, 8'h05, 8'd100, 2'b11, 3'b101, 1'b1, 4'd6}, // R6 enable int
    '{1'b0, 8'h01, 8'd100, 2'b11, 3'b101, 1'b1, 4'd2}, // R2 ext stopped
    '{1'b1, 8'h07, 8'd100, 2'b11, 3'b111, 1'b1, 4'd6}, // R6 all on
    '{1'b0, 8'h00, 8'd100, 2'b00, 3'b111, 1'b1, 4'd7}, // R7 both stages move
    '{1'b0, 8'h02, 8'd1,   2'b10, 3'b111, 1'b0, 4'd5}, // R5 start handoff
    '{1'b0, 8'h00, 8'd100, 2'b10, 3'b111, 1'b1, 4'd5}, // R5 refused mid-handoff
    '{1'b1, 8'h00, 8'd100, 2'b10, 3'b010, 1'b1, 4'd4}, // R4 ext protected
    '{1'b0, 8'h01, 8'd100, 2'b10, 3'b010, 1'b1, 4'd3}  // R3 slow stopped
  };

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_regs(input string req, input logic [1:0] es, input logic [2:0] ee,
                            input bit st);
    rd_addr = 1'b0; #1;
    chk(req, int'(rd_data), int'({6'b0, es}));
    rd_addr = 1'b1; #1;
    chk(req, int'(rd_data), int'({5'b0, ee}));
    chk("R6", int'(osc_en), int'(ee));
    if (st) begin
      chk("R7", int'(hs_src), es[1] ? 2 : 1);
      chk("R7", int'(sys_src), es[0] ? 2 : 1);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    // R1: values while reset is held
    repeat (3) @(negedge clk);
    check_regs("R1", 2'b00, 3'b001, 1'b1);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (60) @(negedge clk);
    check_regs("R1", 2'b00, 3'b001, 1'b1);

    for (int k = 0; k < NV; k++) begin
      bus_write(VEC[k].wa, VEC[k].wd);
      repeat (int'(VEC[k].wt)) @(negedge clk);
      check_regs(req_name(VEC[k].req), VEC[k].exp_sel, VEC[k].exp_en, VEC[k].chk_st);
    end

    // R8: no narrow phases seen on either clock output, and the system clock did toggle
    chk("R8", hs_narrow, 0);
    chk("R8", sys_narrow, 0);
    chk("R8", int'(sys_edges > 200), 1);

    // R1: reset applied mid-run returns every field to its start value
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    check_regs("R1", 2'b00, 3'b001, 1'b0);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (100) @(negedge clk);
    check_regs("R1", 2'b00, 3'b001, 1'b1);

    done = 1;
    finish_run();
  end
endmodule